// File: doc/BRIEF.md
# Host Control Register Bank with Indirect Setup Slot

This block is the host-facing register file of a network controller. A CPU reaches it over an 8-bit bus with a 3-bit address, a write strobe and a read strobe. Five direct addresses are decoded. Two of them form a staged pointer into the controller's packet RAM, one is a configuration register, and one is a sub-address register. The last one, direct address 7, is a shared slot. Behind it sit several setup registers, and the current sub-address value chooses which one the slot reaches.

The block drives the packet-RAM address and a byte-swap flag. It also decodes the setup registers into individual control outputs for the rest of the chip. The pointer is two-phase. Writing its high byte only stages the value. The RAM address changes only when the low byte is written.

Two sub-address bits live in the configuration register and also appear in the sub-address register. Both registers therefore show one value. A third sub-address bit opens the newer setup registers. Any write to the configuration register clears that third bit.

Top module: `hostreg_bank`

## Requirements
- R1: After a synchronous reset the configuration register reads 8'h18 at direct address 2. The sub-address register reads 0. Every setup register reads 0, so all decoded setup outputs are 0. The pointer contents have no defined value until they are written.
- R2: A write to direct address 0 (pointer high) stages a byte that reads back at address 0. `ram_addr` and `byte_swap` do not change.
- R3: A write to direct address 1 (pointer low) with `wide_bus`=0 loads `ram_addr` with {staged high[2:0], written byte} on the next clock edge. It also clears `byte_swap`. The low byte reads back at address 1.
- R4: A pointer-low write with `wide_bus`=1 loads `ram_addr` with address bit 0 forced to 0. It sets `byte_swap` to bit 0 of the written byte.
- R5: A write to direct address 3 sets sub-address bits [2:0] from data bits [2:0]. Address 3 reads {5'b0, sub[2:0]}. The written bits [1:0] also read back as bits [1:0] of the configuration register.
- R6: A write to direct address 2 stores data bits [7:2] as configuration bits. It copies data bits [1:0] into sub-address bits [1:0] and clears sub-address bit 2.
- R7: Direct address 7 reaches a setup register chosen by sub[2:0]. Code 0 selects setup one, code 4 selects setup two, and code 5 selects bus control. Writes store the full byte, and reads return it.
- R8: At address 7, sub-address codes 1, 2, 3, 6 and 7 read as 0. Writes to them leave every setup register unchanged.
- R9: Setup one bits decode as follows: bit 0 is `rate_slow`, bit 1 is `arb_half`, bit 2 is `rx_all` and bit 3 is `pulse_drv_sel`. Bus control drives `bus_ctrl` directly.
- R10: Setup two bits decode as follows: [1:0] is `clk_sel`, bit 2 is `fast_rd_en`, bit 3 is `new_timing_en`, bit 4 is `nosync_init_en` and [6:5] is `recon_sel`.
- R11: `host_rdata` is 0 when `host_rd` is low. Direct addresses 4, 5 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Direct register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, combinational |
| wide_bus | input | 1 | 16-bit access mode enable |
| ram_addr | output | 11 | Committed packet-RAM address |
| byte_swap | output | 1 | Exchange upper and lower data bytes |
| rate_slow | output | 1 | Reduced data rate select |
| arb_half | output | 1 | Halved arbitration speed |
| rx_all | output | 1 | Receive-all enable |
| pulse_drv_sel | output | 1 | Pulse driver type select |
| clk_sel | output | 2 | Generated clock select |
| fast_rd_en | output | 1 | Fast read timing enable |
| new_timing_en | output | 1 | New timing enable |
| nosync_init_en | output | 1 | Allow initialization with a busy line |
| recon_sel | output | 2 | Reconfiguration timeout select |
| bus_ctrl | output | 8 | Bus control register contents |

## Verification
The assertions assume that `host_wr` marks one write per asserted cycle. They also assume that `wide_bus` is steady around a pointer-low write, so the swap flag reflects a single mode. They do not assume anything about the read strobe or about which address is presented. The stimulus drives the inputs on the falling clock edge and holds them for a whole cycle. It mixes random addresses, data and mode values across all eight direct addresses. That mix reaches every sub-address code, including the unassigned ones.

// File: rtl/hostreg_pkg.sv
// Package: shared constants, address map and slot codes for the host register bank.
// Assumes an 8-bit host bus and a 3-bit direct address space.
package hostreg_pkg;
    localparam int DATA_W    = 8;
    localparam int HADDR_W   = 3;
    localparam int SUB_W     = 3;
    localparam int NUM_SLOTS = 3;

    localparam logic [HADDR_W-1:0] A_PTR_HI = 3'd0;
    localparam logic [HADDR_W-1:0] A_PTR_LO = 3'd1;
    localparam logic [HADDR_W-1:0] A_CFG    = 3'd2;
    localparam logic [HADDR_W-1:0] A_SUB    = 3'd3;
    localparam logic [HADDR_W-1:0] A_SLOT   = 3'd7;

    localparam logic [DATA_W-1:0] CFG_RST = 8'h18;

    typedef enum logic [1:0] {
        SLOT_SETUP1 = 2'd0,
        SLOT_SETUP2 = 2'd1,
        SLOT_BUSCTL = 2'd2
    } slot_e;

    // Sub-address code that reaches each indirect slot.
    function automatic logic [SUB_W-1:0] slot_code(input int idx);
        case (idx)
            0:       return 3'd0;
            1:       return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    typedef struct packed {
        logic       recon_rsv;
        logic [1:0] recon_sel;
        logic       nosync;
        logic       new_tmg;
        logic       fast_rd;
        logic [1:0] clk_sel;
    } setup2_t;
endpackage

// File: rtl/hostreg_ptr.sv
// Module: staged packet-RAM pointer.
// A high-byte write only stages its value. A low-byte write commits the full
// address. In wide mode, low bit 0 becomes the byte-swap flag and the address
// bit 0 is forced to zero. Assumes a single-cycle write strobe.
module hostreg_ptr #(
    parameter int RAM_AW = 11,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DW-1:0]     wdata,
    input  logic              wide,
    output logic [DW-1:0]     hi_rd,
    output logic [DW-1:0]     lo_rd,
    output logic [RAM_AW-1:0] addr,
    output logic              swap
);
    localparam int HI_W = RAM_AW - DW;

    logic [DW-1:0] hi_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] lo_eff;

    // Purpose: mask address bit 0 when it acts as the swap control.
    always_comb begin
        lo_eff = wdata;
        if (wide) lo_eff[0] = 1'b0;
    end

    // Purpose: hold the staged high byte and the last low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (wr_hi) hi_q <= wdata;
            if (wr_lo) lo_q <= wdata;
        end
    end

    // Purpose: commit the RAM address and swap flag on a low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            swap <= 1'b0;
        end else if (wr_lo) begin
            addr <= {hi_q[HI_W-1:0], lo_eff};
            swap <= wide & wdata[0];
        end
    end

    assign hi_rd = hi_q;
    assign lo_rd = lo_q;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(addr) && $stable(swap));
    // R4
    swap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap |-> addr[0] == 1'b0);
    // R3
    lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo && !wide |=> addr[DW-1:0] == $past(wdata) && !swap);
endmodule

// File: rtl/hostreg_subsel.sv
// Module: configuration and sub-address registers.
// Sub-address bits [1:0] are a single storage shared by both registers, so
// both registers always show the same value. Bit 2 clears itself on any
// configuration write.
module hostreg_subsel
    import hostreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic              wr_sub,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_rd,
    output logic [DATA_W-1:0] sub_rd,
    output logic [SUB_W-1:0]  sub_sel
);
    localparam int CFG_HI_W = DATA_W - 2;

    logic [CFG_HI_W-1:0] cfg_hi_q;
    logic [SUB_W-1:0]    sub_q;

    // Purpose: update the configuration bits and the shared sub-address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_hi_q <= CFG_RST[DATA_W-1:2];
            sub_q    <= {1'b0, CFG_RST[1:0]};
        end else if (wr_cfg) begin
            cfg_hi_q <= wdata[DATA_W-1:2];
            sub_q    <= {1'b0, wdata[1:0]};
        end else if (wr_sub) begin
            sub_q    <= wdata[SUB_W-1:0];
        end
    end

    assign cfg_rd  = {cfg_hi_q, sub_q[1:0]};
    assign sub_rd  = {{(DATA_W-SUB_W){1'b0}}, sub_q};
    assign sub_sel = sub_q;

    // R6
    sub2_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> sub_sel[2] == 1'b0 && sub_sel[1:0] == $past(wdata[1:0]));
    // R5
    mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sub && !wr_cfg |=> cfg_rd[1:0] == $past(wdata[1:0]));
    // R1
    cfg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> cfg_rd == CFG_RST && sub_rd == '0);
endmodule

// File: rtl/hostreg_setup.sv
// Module: bank of indirect setup registers behind the shared slot.
// Each slot answers one sub-address code. Unassigned codes read as zero and
// do not store writes.
module hostreg_setup
    import hostreg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_slot,
    input  logic [SUB_W-1:0]            sub_sel,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           slot_rd,
    output logic [NUM_SLOTS*DATA_W-1:0] regs_flat
);
    logic [NUM_SLOTS-1:0]  hit;
    logic [DATA_W-1:0]     regs [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign hit[g] = (sub_sel == slot_code(g));

        // Purpose: store one setup register when its code is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                regs[g] <= '0;
            else if (wr_slot && hit[g]) regs[g] <= wdata;
        end

        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    // Purpose: return the selected register, or zero for unassigned codes.
    always_comb begin
        slot_rd = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (hit[i]) slot_rd = regs[i];
    end

    // R7
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R8
    unassigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_slot && hit == '0 |=> $stable(regs_flat));
endmodule

// File: rtl/hostreg_bank.sv
// Module: top of the host register bank.
// Decodes the direct address map, muxes read data, and exports the decoded
// setup fields. Assumes host_wr is one cycle per access. Reads are
// combinational and have no side effects.
module hostreg_bank
    import hostreg_pkg::*;
#(
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    input  logic              wide_bus,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              byte_swap,
    output logic              rate_slow,
    output logic              arb_half,
    output logic              rx_all,
    output logic              pulse_drv_sel,
    output logic [1:0]        clk_sel,
    output logic              fast_rd_en,
    output logic              new_timing_en,
    output logic              nosync_init_en,
    output logic [1:0]        recon_sel,
    output logic [7:0]        bus_ctrl
);
    logic [DATA_W-1:0]           hi_rd, lo_rd, cfg_rd, sub_rd, slot_rd;
    logic [SUB_W-1:0]            sub_sel;
    logic [NUM_SLOTS*DATA_W-1:0] regs_flat;
    logic [DATA_W-1:0]           s1, bc;
    setup2_t                     s2;

    logic wr_hi, wr_lo, wr_cfg, wr_sub, wr_slot;

    assign wr_hi   = host_wr && host_addr == A_PTR_HI;
    assign wr_lo   = host_wr && host_addr == A_PTR_LO;
    assign wr_cfg  = host_wr && host_addr == A_CFG;
    assign wr_sub  = host_wr && host_addr == A_SUB;
    assign wr_slot = host_wr && host_addr == A_SLOT;

    hostreg_ptr #(.RAM_AW(RAM_AW), .DW(DATA_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wdata(host_wdata), .wide(wide_bus), .hi_rd(hi_rd), .lo_rd(lo_rd),
        .addr(ram_addr), .swap(byte_swap)
    );

    hostreg_subsel u_sub (
        .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_sub(wr_sub),
        .wdata(host_wdata), .cfg_rd(cfg_rd), .sub_rd(sub_rd), .sub_sel(sub_sel)
    );

    hostreg_setup u_setup (
        .clk(clk), .rst_n(rst_n), .wr_slot(wr_slot), .sub_sel(sub_sel),
        .wdata(host_wdata), .slot_rd(slot_rd), .regs_flat(regs_flat)
    );

    // Purpose: return the addressed register while the read strobe is high.
    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (host_addr)
                A_PTR_HI: host_rdata = hi_rd;
                A_PTR_LO: host_rdata = lo_rd;
                A_CFG:    host_rdata = cfg_rd;
                A_SUB:    host_rdata = sub_rd;
                A_SLOT:   host_rdata = slot_rd;
                default:  host_rdata = '0;
            endcase
        end
    end

    assign s1 = regs_flat[SLOT_SETUP1*DATA_W +: DATA_W];
    assign s2 = setup2_t'(regs_flat[SLOT_SETUP2*DATA_W +: DATA_W]);
    assign bc = regs_flat[SLOT_BUSCTL*DATA_W +: DATA_W];

    assign rate_slow      = s1[0];
    assign arb_half       = s1[1];
    assign rx_all         = s1[2];
    assign pulse_drv_sel  = s1[3];
    assign clk_sel        = s2.clk_sel;
    assign fast_rd_en     = s2.fast_rd;
    assign new_timing_en  = s2.new_tmg;
    assign nosync_init_en = s2.nosync;
    assign recon_sel      = s2.recon_sel;
    assign bus_ctrl       = bc;

    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_rdata == '0);
    // R9
    setup1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_slot && sub_sel == 3'd0 |=>
            {pulse_drv_sel, rx_all, arb_half, rate_slow} == $past(host_wdata[3:0]));
endmodule

// File: tb/test_hostreg_bank.sv
module test_hostreg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        wide_bus = 1'b0;
    logic [7:0]  host_rdata;
    logic [10:0] ram_addr;
    logic        byte_swap, rate_slow, arb_half, rx_all, pulse_drv_sel;
    logic [1:0]  clk_sel, recon_sel;
    logic        fast_rd_en, new_timing_en, nosync_init_en;
    logic [7:0]  bus_ctrl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    logic [7:0]  m_hi, m_lo, m_cfg, m_s1, m_s2, m_bc;
    logic [2:0]  m_sub;
    logic [10:0] m_addr;
    logic        m_swap;
    bit          ptr_valid;

    always #5 clk = ~clk;

    hostreg_bank i_hostreg_bank (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .wide_bus(wide_bus), .ram_addr(ram_addr), .byte_swap(byte_swap),
        .rate_slow(rate_slow), .arb_half(arb_half), .rx_all(rx_all),
        .pulse_drv_sel(pulse_drv_sel), .clk_sel(clk_sel), .fast_rd_en(fast_rd_en),
        .new_timing_en(new_timing_en), .nosync_init_en(nosync_init_en),
        .recon_sel(recon_sel), .bus_ctrl(bus_ctrl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_hi;
            3'd1: return m_lo;
            3'd2: return {m_cfg[7:2], m_sub[1:0]};
            3'd3: return {5'b0, m_sub};
            3'd7: case (m_sub)
                      3'd0: return m_s1;
                      3'd4: return m_s2;
                      3'd5: return m_bc;
                      default: return 8'h00;
                  endcase
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: m_hi = d;
            3'd1: begin
                m_lo = d;
                m_addr = {m_hi[2:0], wide_bus ? {d[7:1], 1'b0} : d};
                m_swap = wide_bus & d[0];
                ptr_valid = 1;
            end
            3'd2: begin m_cfg = d; m_sub = {1'b0, d[1:0]}; end
            3'd3: m_sub = d[2:0];
            3'd7: case (m_sub)
                      3'd0: m_s1 = d;
                      3'd4: m_s2 = d;
                      3'd5: m_bc = d;
                      default: ;
                  endcase
            default: ;
        endcase
    endtask

    // Drive at falling edge; the register updates at the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(input string req, input logic [2:0] a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1;
        check(req, host_rdata, exp_read(a));
        host_rd = 1'b0;
    endtask

    task automatic check_outputs(input string req);
        check({req, " setup1"}, {pulse_drv_sel, rx_all, arb_half, rate_slow}, m_s1[3:0]);
        check({req, " setup2"},
              {recon_sel, nosync_init_en, new_timing_en, fast_rd_en, clk_sel}, m_s2[6:0]);
        check({req, " busctl"}, bus_ctrl, m_bc);
        if (ptr_valid) begin
            check({req, " ram_addr"}, ram_addr, m_addr);
            check({req, " swap"}, byte_swap, m_swap);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_hi = 0; m_lo = 0; m_cfg = 8'h18; m_sub = 0; m_s1 = 0; m_s2 = 0; m_bc = 0;
        m_addr = 0; m_swap = 0; ptr_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check("R1 cfg reset", 3'd2);
        check("R1 cfg value", exp_read(3'd2), 8'h18);
        rd_check("R1 sub reset", 3'd3);
        rd_check("R1 slot reset", 3'd7);
        check_outputs("R1");

        // R11 idle bus reads zero; unmapped addresses read zero
        @(negedge clk); host_addr = 3'd2; #1;
        check("R11 idle rdata", host_rdata, 8'h00);
        rd_check("R11 addr4", 3'd4);
        rd_check("R11 addr5", 3'd5);
        rd_check("R11 addr6", 3'd6);

        // R3 narrow pointer commit
        wr(3'd0, 8'h05); wr(3'd1, 8'hA7);
        check("R3 ram_addr", ram_addr, 11'h5A7);
        check("R3 swap", byte_swap, 1'b0);
        rd_check("R3 lo readback", 3'd1);

        // R2 staging does not move the pointer
        wr(3'd0, 8'h02);
        check("R2 addr held", ram_addr, 11'h5A7);
        rd_check("R2 hi readback", 3'd0);

        // R4 wide mode swap
        wide_bus = 1'b1;
        wr(3'd1, 8'h33);
        check("R4 ram_addr", ram_addr, 11'h232);
        check("R4 swap", byte_swap, 1'b1);
        wr(3'd1, 8'h44);
        check("R4 swap clear", byte_swap, 1'b0);
        wide_bus = 1'b0;

        // R5 sub write and mirror; reserved bits read zero
        wr(3'd3, 8'hFE);
        rd_check("R5 sub readback", 3'd3);
        rd_check("R5 cfg mirror", 3'd2);

        // R6 config write clears bit 2
        wr(3'd3, 8'h04);
        wr(3'd2, 8'hC3);
        rd_check("R6 sub after cfg", 3'd3);
        check("R6 sub value", exp_read(3'd3), 8'h03);

        // R7 / R10 setup two and bus control
        wr(3'd3, 8'h04); wr(3'd7, 8'h75);
        rd_check("R7 setup2", 3'd7);
        check_outputs("R10");
        wr(3'd3, 8'h05); wr(3'd7, 8'h9C);
        rd_check("R7 busctl", 3'd7);
        // R9 setup one
        wr(3'd3, 8'h00); wr(3'd7, 8'h0B);
        check_outputs("R9");

        // R8 unassigned codes
        for (int c = 1; c < 8; c++) begin
            if (c == 4 || c == 5) continue;
            wr(3'd3, 8'(c)); wr(3'd7, 8'hFF);
            rd_check("R8 unassigned read", 3'd7);
            check_outputs("R8");
        end

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            wide_bus = 1'($urandom);
            if ($urandom_range(0, 2) == 0) rd_check("R7 random read", a);
            else begin
                wr(a, d);
                check_outputs("R3 random");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule